// File: doc/BRIEF.md
# Per-Channel Output Enable and Transmit Fault Latch

This block decides, for each of four lanes, whether the transmit output and the receive output are allowed to drive. It combines software control bits with live loss-of-signal indications from both directions and with the transmit fault detectors. A lane whose transmit fault detector fires is locked out in a latched fault state. The lane leaves that state only when software pulses its transmit disable bit high and then low again, or on reset. In both cases the fault input must have gone low.

Software writes control bytes through a simple write port. Each byte is picked by a two-bit select and applies at the clock edge that samples the write. The outputs follow the stored control bits and the loss-of-signal inputs without any register stage. Only the fault state is sampled.

Top module: `chanEnableCtl`

## Requirements
- R1: After reset all control bits are 0, every fault state bit is 0, and with no loss of signal and no fault every txEn and rxEn bit is 1.
- R2: A write with wrAddr = 0 loads the transmit disable bits from wrData[3:0], bit i for lane i. From the sampling edge, txEn[i] is 0 for every lane whose bit is 1.
- R3: While txLos[i] is 1, txEn[i] is 0 unless the lane's transmit squelch override is set. The override is wrData[i] of a write with wrAddr = 1. When it is set, txLos[i] has no effect on txEn[i].
- R4: While rxLos[i] is 1, rxEn[i] is 0 unless the lane's receive squelch override is set. The override is wrData[4+i] of a write with wrAddr = 1.
- R5: A write with wrAddr = 2 loads the receive output disable bits from wrData[7:4], bit 4+i for lane i. From the sampling edge, rxEn[i] is 0 for every lane whose bit is 1, whatever the state of rxLos.
- R6: A clock edge that samples txFault[i] = 1 sets faultState[i]. From that edge txEn[i] is 0. The bit stays set after txFault[i] returns to 0.
- R7: A set faultState[i] clears at the first edge after the write that takes the lane's transmit disable bit from 1 to 0, provided txFault[i] is 0 at that edge. It does not clear without that 1-to-0 change.
- R8: If txFault[i] is 1 at the edge where recovery would occur, faultState[i] stays 1.
- R9: A transmit fault affects neither rxEn nor any other lane.
- R10: Reset clears all fault state bits and all control bits. If txFault[i] is still 1, faultState[i] sets again at the first edge after reset is released.
- R11: Writes with wrAddr = 3 have no effect. wrData[7:4] of a wrAddr = 0 write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Control write strobe |
| wrAddr | input | 2 | Control byte select |
| wrData | input | 8 | Control byte |
| txLos | input | 4 | Transmit input loss of signal, per lane |
| rxLos | input | 4 | Receive input loss of signal, per lane |
| txFault | input | 4 | Transmit fault detector, per lane |
| txEn | output | 4 | Transmit output enable, per lane |
| rxEn | output | 4 | Receive output enable, per lane |
| faultState | output | 4 | Latched transmit fault, per lane |

## Verification
A lost or stuck fault latch shows in the same cycle on faultState and txEn. A fault that clears without a complete disable pulse shows at once as a transmit lane coming back. A recovery that ignores a fault still present also shows at once. The disable edge detector is the subtle state: if it misses a pulse, the lane stays dark one edge after the clearing write, when it should already be driving. If it fires on a write that leaves the bit unchanged, the lane recovers when it should not. Squelch override and output disable errors show on txEn or rxEn in the cycle after the write.

// File: rtl/chanEnablePkg.sv
package chanEnablePkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TXDIS = 2'd0,
    SEL_SQDIS = 2'd1,
    SEL_RXDIS = 2'd2,
    SEL_NONE  = 2'd3
  } ctlSel_e;

  typedef struct packed {
    logic txDisWr;
    logic sqDisWr;
    logic rxDisWr;
  } ctlStrobes_t;

endpackage

// File: rtl/chanEnableCtrl.sv
module chanEnableCtrl
  import chanEnablePkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output ctlStrobes_t       strobes
);

  ctlSel_e sel;

  always_comb begin
    sel = ctlSel_e'(wrAddr);
    strobes = '0;
    if (wrEn) begin
      case (sel)
        SEL_TXDIS: strobes.txDisWr = 1'b1;
        SEL_SQDIS: strobes.sqDisWr = 1'b1;
        SEL_RXDIS: strobes.rxDisWr = 1'b1;
        default:   strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/txFaultCell.sv
module txFaultCell (
  input  logic clk,
  input  logic rstN,
  input  logic disBit,
  input  logic faultIn,
  output logic faultQ
);

  logic disPrev;
  logic disFell;

  assign disFell = disPrev & ~disBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      disPrev <= 1'b0;
      faultQ  <= 1'b0;
    end else begin
      disPrev <= disBit;
      if (faultIn)
        faultQ <= 1'b1;
      else if (disFell)
        faultQ <= 1'b0;
    end
  end

endmodule

// File: rtl/chanEnableDp.sv
module chanEnableDp
  import chanEnablePkg::*;
#(
  parameter int NCH = 4,
  localparam int DW = 2 * NCH
) (
  input  logic           clk,
  input  logic           rstN,
  input  ctlStrobes_t    strobes,
  input  logic [DW-1:0]  wrData,
  input  logic [NCH-1:0] txLos,
  input  logic [NCH-1:0] rxLos,
  input  logic [NCH-1:0] txFault,
  output logic [NCH-1:0] txEn,
  output logic [NCH-1:0] rxEn,
  output logic [NCH-1:0] faultState
);

  logic [NCH-1:0] txDis;
  logic [NCH-1:0] txSqDis;
  logic [NCH-1:0] rxSqDis;
  logic [NCH-1:0] rxDis;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txDis   <= '0;
      txSqDis <= '0;
      rxSqDis <= '0;
      rxDis   <= '0;
    end else begin
      if (strobes.txDisWr) txDis <= wrData[NCH-1:0];
      if (strobes.sqDisWr) begin
        txSqDis <= wrData[NCH-1:0];
        rxSqDis <= wrData[DW-1:NCH];
      end
      if (strobes.rxDisWr) rxDis <= wrData[DW-1:NCH];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic txSquelch;
    logic rxSquelch;

    txFaultCell u_fault (
      .clk    (clk),
      .rstN   (rstN),
      .disBit (txDis[ch]),
      .faultIn(txFault[ch]),
      .faultQ (faultState[ch])
    );

    assign txSquelch = txLos[ch] & ~txSqDis[ch];
    assign rxSquelch = rxLos[ch] & ~rxSqDis[ch];
    assign txEn[ch]  = ~txDis[ch] & ~faultState[ch] & ~txSquelch;
    assign rxEn[ch]  = ~rxDis[ch] & ~rxSquelch;
  end

endmodule

// File: rtl/chanEnableCtl.sv
module chanEnableCtl
  import chanEnablePkg::*;
#(
  parameter int NCH = 4,
  localparam int DW = 2 * NCH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [NCH-1:0]    txLos,
  input  logic [NCH-1:0]    rxLos,
  input  logic [NCH-1:0]    txFault,
  output logic [NCH-1:0]    txEn,
  output logic [NCH-1:0]    rxEn,
  output logic [NCH-1:0]    faultState
);

  ctlStrobes_t strobes;

  chanEnableCtrl u_ctrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobes(strobes)
  );

  chanEnableDp #(.NCH(NCH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (wrData),
    .txLos     (txLos),
    .rxLos     (rxLos),
    .txFault   (txFault),
    .txEn      (txEn),
    .rxEn      (rxEn),
    .faultState(faultState)
  );

endmodule

// File: rtl/chanEnableCtl_chk.sv
module chanEnableCtl_chk #(
  parameter int NCH = 4,
  localparam int DW = 2 * NCH
) (
  input logic           clk,
  input logic           rstN,
  input logic           wrEn,
  input logic [1:0]     wrAddr,
  input logic [DW-1:0]  wrData,
  input logic [NCH-1:0] txFault,
  input logic [NCH-1:0] txEn,
  input logic [NCH-1:0] rxEn,
  input logic [NCH-1:0] faultState
);

  AST_TXDIS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> ((txEn & $past(wrData[NCH-1:0])) == '0)); // R2

  AST_RXDIS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd2) |=> ((rxEn & $past(wrData[DW-1:NCH])) == '0)); // R5

  AST_FAULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|txFault) |=> ((faultState & $past(txFault)) == $past(txFault))); // R6

  AST_FAULT_TX_OFF: assert property (@(posedge clk) disable iff (!rstN)
    ((faultState & txEn) == '0)); // R6

  AST_NO_CLEAR_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (($past(faultState) & ~faultState & $past(txFault)) == '0)); // R8

endmodule

bind chanEnableCtl chanEnableCtl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .txFault   (txFault),
  .txEn      (txEn),
  .rxEn      (rxEn),
  .faultState(faultState)
);

// File: tb/chanEnableCtl_bench.sv
module chanEnableCtl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] txLos = '0;
  logic [3:0] rxLos = '0;
  logic [3:0] txFault = '0;
  logic [3:0] txEn;
  logic [3:0] rxEn;
  logic [3:0] faultState;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] tx;
    logic [3:0] rx;
    logic [3:0] f;
    string      tag;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  chanEnableCtl u_chanEnableCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .txLos(txLos), .rxLos(rxLos), .txFault(txFault),
    .txEn(txEn), .rxEn(rxEn), .faultState(faultState)
  );

  // driver: inputs change at the falling edge, the result is due after the next rising edge
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                      input logic [3:0] tl, input logic [3:0] rl, input logic [3:0] fl,
                      input logic rn);
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d;
    txLos = tl; rxLos = rl; txFault = fl; rstN = rn;
  endtask

  task automatic expectOut(input logic [3:0] tx, input logic [3:0] rx,
                           input logic [3:0] f, input string tag);
    exp_t e;
    e.tx = tx; e.rx = rx; e.f = f; e.tag = tag;
    expQ.push_back(e);
  endtask

  // monitor: compares shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (txEn !== e.tx || rxEn !== e.rx || faultState !== e.f) begin
          failures++;
          $display("FAIL %s: txEn=%h rxEn=%h fault=%h expected txEn=%h rxEn=%h fault=%h",
                   e.tag, txEn, rxEn, faultState, e.tx, e.rx, e.f);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hF, 4'hF, 4'h0, "R1 reset state");
    step(1, 0, 8'hF5, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hA, 4'hF, 4'h0, "R2 R11 tx disable, upper bits ignored");
    step(1, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hF, 4'hF, 4'h0, "R2 tx disable cleared");
    step(0, 0, 8'h00, 4'h3, 4'h8, 4'h0, 1); expectOut(4'hC, 4'h7, 4'h0, "R3 R4 squelch on los");
    step(1, 1, 8'h81, 4'h3, 4'h8, 4'h0, 1); expectOut(4'hD, 4'hF, 4'h0, "R3 R4 squelch override");
    step(1, 2, 8'h20, 4'h3, 4'h8, 4'h0, 1); expectOut(4'hD, 4'hD, 4'h0, "R5 rx output disable");
    step(1, 3, 8'hFF, 4'h3, 4'h8, 4'h0, 1); expectOut(4'hD, 4'hD, 4'h0, "R11 unused select ignored");
    step(1, 1, 8'h00, 4'h3, 4'h8, 4'h0, 1); expectOut(4'hC, 4'h5, 4'h0, "R3 R4 override removed");
    step(1, 2, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hF, 4'hF, 4'h0, "R5 rx disable cleared");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h4, 1); expectOut(4'hB, 4'hF, 4'h4, "R6 R9 fault latches");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hB, 4'hF, 4'h4, "R6 fault held");
    step(1, 0, 8'h04, 4'h0, 4'h0, 4'h4, 1); expectOut(4'hB, 4'hF, 4'h4, "R8 disable set in fault");
    step(1, 0, 8'h00, 4'h0, 4'h0, 4'h4, 1); expectOut(4'hB, 4'hF, 4'h4, "R8 disable cleared in fault");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h4, 1); expectOut(4'hB, 4'hF, 4'h4, "R8 no recovery while fault high");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hB, 4'hF, 4'h4, "R7 no recovery without toggle");
    step(1, 0, 8'h04, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hB, 4'hF, 4'h4, "R7 disable set");
    step(1, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hB, 4'hF, 4'h4, "R7 disable cleared");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hF, 4'hF, 4'h0, "R7 recovered");
    step(1, 2, 8'hF0, 4'h0, 4'h0, 4'h8, 1); expectOut(4'h7, 4'h0, 4'h8, "R5 R6 R9 fault and rx disable");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h8, 0); expectOut(4'hF, 4'hF, 4'h0, "R10 reset clears");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h8, 1); expectOut(4'h7, 4'hF, 4'h8, "R10 relatch after reset");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 0); expectOut(4'hF, 4'hF, 4'h0, "R10 reset recovers");
    step(0, 0, 8'h00, 4'h0, 4'h0, 4'h0, 1); expectOut(4'hF, 4'hF, 4'h0, "R10 R1 after reset");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule